// File: doc/BRIEF.md
# Keypad Matrix Scan Controller

This block scans a keypad matrix of up to 16 row lines and 16 column lines and stores the result as one 16-bit word per row. Software sets the scan mode, the settle time per row and the pause between scans through a small word-addressed register bus. It then reads the row words back, or waits for the interrupt line. There are four modes. Mode 0 leaves the matrix idle. Mode 1 drives every enabled row at once and reports any pressed key. Mode 2 makes one pass over the rows and drops back to idle. Mode 3 repeats the pass after a programmed gap.

Row outputs are active-low. During a pass exactly one row is driven low. In detect mode all rows named by the row mask are driven low together. Column inputs are active-low and pass through a two-flop synchronizer before they are sampled. A row is sampled at the end of its settle count, so that count must be at least 2. Writing the control register aborts whatever is in progress and starts the newly written mode on the following clock.

The register map uses word offsets on `busAddr`:
- word 0: control
- word 1: size/mask
- word 2: interrupt status
- word 3: interrupt enable
- words 4 to 11: row data

Row data word 4+j returns row 2j in bits [15:0] and row 2j+1 in bits [31:16]. A read returns its data on `busRdata` one clock after `busRd` is sampled high.

Top module: `kpad_scan_top`

## Requirements
- R1: After reset:
  - control reads 0x0F0003C0 (pause 0x0F00, settle 0xF0, mode 0);
  - size/mask reads 0xFFFF1010;
  - status reads 0;
  - `irq` is low;
  - all `rowN` lines are high.
- R2: Control word layout:
  - bits [1:0] hold the mode;
  - bits [15:2] hold the per-row settle count;
  - bits [31:16] hold the inter-scan pause count.

  Size/mask word layout:
  - bits [7:0] hold the row count;
  - bits [15:8] hold the column count;
  - bits [31:16] hold the detect-mode row mask.

  Row data word 4+j packs rows 2j (low half) and 2j+1 (high half).
- R3: In mode 2 the rows are driven low one at a time, starting at row 0. Each row word is loaded with the pressed columns, where a pressed column has bit = 1. When the pass ends, status bit 0 is set and the mode field returns to 0.
- R4: In mode 3 the pass repeats after the pause, and the mode field stays 3. Later key changes therefore appear in the row words without being written again.
- R5: When a row is loaded, column bits at or above the column count are written as 0.
- R6: Row words at or above the row count keep their previous contents. A row count or column count of 0 completes the pass at once: only status bit 0 is set and no row word changes.
- R7: Status bit 1 is set whenever a row word is loaded with a value that differs from its old one.
- R8: In mode 1 every row whose mask bit is 1 is driven low together. Each such row word is loaded with the OR of the columns pressed on all of those rows. Row words outside the mask are untouched.
- R9: In mode 1, status bit 2 is set only by a pressed column whose index has a 1 in the row mask. Pressed columns outside the mask still appear in the row words.
- R10: While a qualifying key stays pressed in mode 1, status bit 2 stays set, and writing 1 to it has no effect.
- R11: Writing 1 to a status bit clears it. `irq` is high exactly when some status bit and its enable bit (enable word bits [2:0]) are both 1.
- R12: Writing the control register during a pass aborts it. With mode 0 written, all rows go high on the next clock, and no completion is ever flagged for the aborted pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe; data follows one cycle later |
| busAddr | input | 4 | Word offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| colN | input | 16 | Active-low column inputs, asynchronous |
| rowN | output | 16 | Active-low row drive lines |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
The assertions assume that the bus issues single-cycle writes and never a read and a write in the same cycle. They also assume that the settle count is at least 2, so that the synchronized column value has caught up with the driven row before it is sampled. The stimulus always programs a settle count of 4 or more. It changes key positions only while the controller is idle, or in a mode where a change is harmless. The keypad model answers row drive combinationally, the way a real switch matrix does.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SCAN,
    ST_GAP,
    ST_DETECT
  } kpadState_t;

  typedef struct packed {
    logic latchRow;   // load the current row word from the columns
    logic scanDone;   // a pass has finished
    logic modeClear;  // single pass over: return mode field to idle
    logic detect;     // any-key detect active this cycle
  } kpadStrobe_t;

  localparam logic [3:0] REG_CTRL   = 4'd0;
  localparam logic [3:0] REG_SIZE   = 4'd1;
  localparam logic [3:0] REG_STATUS = 4'd2;
  localparam logic [3:0] REG_ENABLE = 4'd3;
  localparam logic [3:0] REG_DATA0  = 4'd4;

  localparam logic [31:0] CTRL_RESET = 32'h0F00_03C0;
  localparam logic [31:0] SIZE_RESET = 32'hFFFF_1010;

endpackage

// File: rtl/kpad_scan_ctrl.sv
module kpad_scan_ctrl
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          mode,
  input  logic [13:0]         rowDelay,
  input  logic [15:0]         scanGap,
  input  logic [7:0]          rowCount,
  input  logic [7:0]          colCount,
  input  logic [15:0]         rowMask,
  input  logic                ctrlWr,
  output kpadStrobe_t         strobe,
  output logic [ROW_W-1:0]    rowIdx,
  output logic [NUM_ROWS-1:0] rowN
);

  kpadState_t       state;
  logic [15:0]      cnt;
  logic [ROW_W-1:0] row;
  logic [7:0]       rowLimit;
  logic             emptyScan;
  logic             rowEnd;
  logic             isLast;

  assign rowLimit  = (rowCount > 8'(NUM_ROWS)) ? 8'(NUM_ROWS) : rowCount;
  assign emptyScan = (state == ST_START) && mode[1] &&
                     ((rowLimit == 8'd0) || (colCount == 8'd0));
  assign rowEnd    = (state == ST_SCAN) && (cnt == {2'b00, rowDelay});
  assign isLast    = ({{(8-ROW_W){1'b0}}, row} == (rowLimit - 8'd1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      row   <= '0;
    end else if (ctrlWr) begin
      state <= ST_START;
      cnt   <= '0;
      row   <= '0;
    end else begin
      case (state)
        ST_START: begin
          cnt <= '0;
          row <= '0;
          case (mode)
            2'd0:    state <= ST_IDLE;
            2'd1:    state <= ST_DETECT;
            default: begin
              if (emptyScan) state <= (mode == 2'd2) ? ST_IDLE : ST_GAP;
              else           state <= ST_SCAN;
            end
          endcase
        end
        ST_SCAN: begin
          if (rowEnd) begin
            cnt <= '0;
            if (isLast) state <= (mode == 2'd2) ? ST_IDLE : ST_GAP;
            else        row   <= row + 1'b1;
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        ST_GAP: begin
          if (cnt == scanGap) begin
            state <= ST_START;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    strobe.latchRow  = rowEnd && !ctrlWr;
    strobe.scanDone  = (emptyScan || (rowEnd && isLast)) && !ctrlWr;
    strobe.modeClear = strobe.scanDone && (mode == 2'd2);
    strobe.detect    = (state == ST_DETECT) && !ctrlWr;
  end

  assign rowIdx = row;

  always_comb begin
    case (state)
      ST_SCAN:   rowN = ~(NUM_ROWS'(1) << row);
      ST_DETECT: rowN = ~rowMask[NUM_ROWS-1:0];
      default:   rowN = '1;
    endcase
  end

  // R3: a pass drives exactly one row low at a time
  a_r3_one_row_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> ($countones(~rowN) == 1));

  // R12: a control write releases every row on the next clock
  a_r12_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (rowN == '1));

  // R6: no row at or beyond the programmed count is ever loaded
  a_r6_row_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchRow |-> ({{(8-ROW_W){1'b0}}, rowIdx} < rowCount));

endmodule

// File: rtl/kpad_scan_dp.sv
module kpad_scan_dp
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 16,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [3:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_COLS-1:0] colN,
  input  kpadStrobe_t         strobe,
  input  logic [ROW_W-1:0]    rowIdx,
  output logic [1:0]          mode,
  output logic [13:0]         rowDelay,
  output logic [15:0]         scanGap,
  output logic [7:0]          rowCount,
  output logic [7:0]          colCount,
  output logic [15:0]         rowMask,
  output logic                ctrlWr,
  output logic                irq
);

  logic [31:0]         ctrlQ;
  logic [31:0]         sizeQ;
  logic [2:0]          statusQ;
  logic [2:0]          enableQ;
  logic [15:0]         dataQ [NUM_ROWS];
  logic [15:0]         rowView [16];
  logic [NUM_COLS-1:0] colSync1;
  logic [NUM_COLS-1:0] colSync2;
  logic [15:0]         pressed;
  logic [15:0]         colMask;
  logic [15:0]         pressedM;
  logic                dataChanged;
  logic                keyQual;
  logic [2:0]          statusClr;
  logic [2:0]          statusSet;
  logic [3:0]          pairIdx;

  assign mode     = ctrlQ[1:0];
  assign rowDelay = ctrlQ[15:2];
  assign scanGap  = ctrlQ[31:16];
  assign rowCount = sizeQ[7:0];
  assign colCount = sizeQ[15:8];
  assign rowMask  = sizeQ[31:16];
  assign ctrlWr   = busWr && (busAddr == REG_CTRL);

  // two-flop synchronizer on the asynchronous column lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colSync1 <= '1;
      colSync2 <= '1;
    end else begin
      colSync1 <= colN;
      colSync2 <= colSync1;
    end
  end

  assign pressed = 16'(~colSync2);

  always_comb begin
    for (int i = 0; i < 16; i++) colMask[i] = (8'(i) < colCount);
  end

  assign pressedM = pressed & colMask;
  assign keyQual  = strobe.detect && |(pressed & rowMask);

  always_comb begin
    dataChanged = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (((strobe.latchRow && rowIdx == ROW_W'(r)) ||
           (strobe.detect && rowMask[r])) && (dataQ[r] != pressedM))
        dataChanged = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ROWS; r++) dataQ[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        if ((strobe.latchRow && rowIdx == ROW_W'(r)) ||
            (strobe.detect && rowMask[r]))
          dataQ[r] <= pressedM;
      end
    end
  end

  assign statusClr = (busWr && busAddr == REG_STATUS) ? busWdata[2:0] : 3'b000;
  assign statusSet = {keyQual, dataChanged, strobe.scanDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= CTRL_RESET;
      sizeQ   <= SIZE_RESET;
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      if (ctrlWr)                  ctrlQ      <= busWdata;
      else if (strobe.modeClear)   ctrlQ[1:0] <= 2'd0;
      if (busWr && busAddr == REG_SIZE)   sizeQ   <= busWdata;
      if (busWr && busAddr == REG_ENABLE) enableQ <= busWdata[2:0];
      statusQ <= (statusQ & ~statusClr) | statusSet;
    end
  end

  assign irq = |(statusQ & enableQ);

  for (genvar g = 0; g < 16; g++) begin : g_view
    if (g < NUM_ROWS) begin : g_real
      assign rowView[g] = dataQ[g];
    end else begin : g_pad
      assign rowView[g] = '0;
    end
  end

  assign pairIdx = busAddr - REG_DATA0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRd) begin
      case (busAddr)
        REG_CTRL:   busRdata <= ctrlQ;
        REG_SIZE:   busRdata <= sizeQ;
        REG_STATUS: busRdata <= {29'd0, statusQ};
        REG_ENABLE: busRdata <= {29'd0, enableQ};
        default: begin
          if (busAddr >= REG_DATA0 && pairIdx < 4'd8)
            busRdata <= {rowView[{pairIdx[2:0], 1'b1}], rowView[{pairIdx[2:0], 1'b0}]};
          else
            busRdata <= '0;
        end
      endcase
    end
  end

  // R10: a held qualifying key keeps status bit 2 set regardless of writes
  a_r10_sticky_detect: assert property (@(posedge clk) disable iff (!rstN)
    keyQual |=> statusQ[2]);

  // R3: a finished single pass returns the mode field to idle
  a_r3_mode_return: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.modeClear && !ctrlWr) |=> (mode == 2'd0));

  // R11: a write of 1 clears bit 0 unless a completion arrives that cycle
  a_r11_w1c_done: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == REG_STATUS && busWdata[0] && !strobe.scanDone) |=> !statusQ[0]);

  // R9: without any pressed column inside the mask, bit 2 cannot rise
  a_r9_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
    !(|(pressed & rowMask)) |=> !$rose(statusQ[2]));

endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
  import kpad_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 16,
  localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [3:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_COLS-1:0] colN,
  output logic [NUM_ROWS-1:0] rowN,
  output logic                irq
);

  kpadStrobe_t      strobe;
  logic [ROW_W-1:0] rowIdx;
  logic [1:0]       mode;
  logic [13:0]      rowDelay;
  logic [15:0]      scanGap;
  logic [7:0]       rowCount;
  logic [7:0]       colCount;
  logic [15:0]      rowMask;
  logic             ctrlWr;

  kpad_scan_dp #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .colN(colN), .strobe(strobe), .rowIdx(rowIdx), .mode(mode),
    .rowDelay(rowDelay), .scanGap(scanGap), .rowCount(rowCount),
    .colCount(colCount), .rowMask(rowMask), .ctrlWr(ctrlWr), .irq(irq)
  );

  kpad_scan_ctrl #(.NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .rowDelay(rowDelay),
    .scanGap(scanGap), .rowCount(rowCount), .colCount(colCount),
    .rowMask(rowMask), .ctrlWr(ctrlWr), .strobe(strobe),
    .rowIdx(rowIdx), .rowN(rowN)
  );

endmodule

// File: tb/kpad_scan_top_test.sv
`timescale 1ns/1ps
module kpad_scan_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] colN;
  logic [15:0] rowN;
  logic        irq;
  logic [15:0] keys [16];

  int nChecks = 0;
  int nFail   = 0;
  logic rdPend = 1'b0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  kpad_scan_top uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .colN(colN), .rowN(rowN), .irq(irq)
  );

  // switch matrix: a column is pulled low if a low row has that key closed
  always_comb begin
    for (int c = 0; c < 16; c++) begin
      colN[c] = 1'b1;
      for (int r = 0; r < 16; r++)
        if (!rowN[r] && keys[r][c]) colN[c] = 1'b0;
    end
  end

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // driver: queue the expected value, issue the read
  task automatic expectRead(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  always @(posedge clk) rdPend <= busRd;

  // monitor: compare returned read data against the queue
  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0)
      checkVal(tagQ.pop_front(), busRdata, expQ.pop_front());
  end

  task automatic clearKeys();
    for (int r = 0; r < 16; r++) keys[r] = '0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    waitCycles(3);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    clearKeys();
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    checkVal("R1 rowN", {16'd0, rowN}, 32'h0000_FFFF);
    checkVal("R1 irq", {31'd0, irq}, 32'd0);
    expectRead(4'd0, 32'h0F00_03C0, "R1 ctrl");
    expectRead(4'd1, 32'hFFFF_1010, "R1 size");
    expectRead(4'd2, 32'd0, "R1 status");

    // R3 R2 R7 single pass, 16 rows, 16 cols, settle 4, gap 8
    busWrite(4'd3, 32'd7);
    busWrite(4'd1, 32'hFFFF_1010);
    keys[3] = 16'h0020;
    keys[15] = 16'h0001;
    busWrite(4'd0, 32'h0008_0012);
    @(negedge clk);
    checkVal("R3 first row driven", {16'd0, rowN}, 32'h0000_FFFE);
    waitCycles(150);
    expectRead(4'd0, 32'h0008_0010, "R3 mode back to idle");
    expectRead(4'd4, 32'h0000_0000, "R2 rows 0/1");
    expectRead(4'd5, 32'h0020_0000, "R2 rows 2/3");
    expectRead(4'd11, 32'h0001_0000, "R2 rows 14/15");
    expectRead(4'd2, 32'h0000_0003, "R7 status done+changed");
    checkVal("R11 irq high", {31'd0, irq}, 32'd1);
    checkVal("R3 rows idle", {16'd0, rowN}, 32'h0000_FFFF);

    // R11 write-one-to-clear
    busWrite(4'd2, 32'd3);
    expectRead(4'd2, 32'd0, "R11 status cleared");
    checkVal("R11 irq low", {31'd0, irq}, 32'd0);

    // R5 column count 4
    keys[2] = 16'h0082;
    busWrite(4'd1, 32'hFFFF_0410);
    busWrite(4'd0, 32'h0008_0012);
    waitCycles(150);
    expectRead(4'd5, 32'h0000_0002, "R5 high columns zero");
    expectRead(4'd11, 32'h0001_0000, "R5 row15 col0 kept");

    // R6 row count 2: row3 stays stale
    clearKeys();
    keys[0] = 16'h0001;
    keys[3] = 16'h0001;
    busWrite(4'd2, 32'd7);
    busWrite(4'd1, 32'hFFFF_1002);
    busWrite(4'd0, 32'h0008_0012);
    waitCycles(60);
    expectRead(4'd4, 32'h0000_0001, "R6 row0 loaded");
    expectRead(4'd5, 32'h0000_0002, "R6 rows 2/3 stale");
    expectRead(4'd2, 32'h0000_0003, "R6 status");

    // R6 row count 0 completes at once
    busWrite(4'd2, 32'd7);
    busWrite(4'd1, 32'hFFFF_1000);
    busWrite(4'd0, 32'h0008_0012);
    waitCycles(5);
    expectRead(4'd2, 32'h0000_0001, "R6 empty pass done only");
    expectRead(4'd0, 32'h0008_0010, "R6 empty pass mode idle");
    expectRead(4'd4, 32'h0000_0001, "R6 empty pass data kept");

    // R8 R9 detect mode, mask rows/cols 2 and 3
    clearKeys();
    busWrite(4'd2, 32'd7);
    busWrite(4'd1, 32'h000C_1010);
    keys[2] = 16'h0002;
    keys[5] = 16'h0004;
    busWrite(4'd0, 32'h0008_0011);
    waitCycles(10);
    checkVal("R8 masked rows low", {16'd0, rowN}, 32'h0000_FFF3);
    expectRead(4'd5, 32'h0002_0002, "R8 OR in both rows");
    expectRead(4'd4, 32'h0000_0001, "R8 unmasked row0 untouched");
    expectRead(4'd2, 32'h0000_0002, "R9 col1 outside mask no detect");
    keys[3] = 16'h0008;
    waitCycles(10);
    expectRead(4'd5, 32'h000A_000A, "R8 OR of two rows");
    expectRead(4'd2, 32'h0000_0006, "R9 col3 sets detect");

    // R10 sticky while held
    busWrite(4'd2, 32'd4);
    expectRead(4'd2, 32'h0000_0006, "R10 clear ignored while held");
    clearKeys();
    waitCycles(10);
    busWrite(4'd2, 32'd7);
    expectRead(4'd2, 32'd0, "R10 clears after release");

    // R4 continuous, one row
    keys[0] = 16'h0010;
    busWrite(4'd1, 32'hFFFF_1001);
    busWrite(4'd0, 32'h0008_0013);
    waitCycles(60);
    expectRead(4'd4, 32'h0000_0010, "R4 first pass");
    keys[0] = 16'h0040;
    waitCycles(60);
    expectRead(4'd4, 32'h0000_0040, "R4 later pass picks change");
    expectRead(4'd0, 32'h0008_0013, "R4 mode stays continuous");

    // R12 abort a long pass
    clearKeys();
    busWrite(4'd1, 32'hFFFF_1010);
    busWrite(4'd0, 32'h0008_0190);
    busWrite(4'd2, 32'd7);
    busWrite(4'd0, 32'h0008_0192);
    waitCycles(20);
    checkVal("R12 pass running", {16'd0, rowN}, 32'h0000_FFFE);
    busWrite(4'd0, 32'h0008_0190);
    checkVal("R12 rows released", {16'd0, rowN}, 32'h0000_FFFF);
    waitCycles(700);
    expectRead(4'd2, 32'd0, "R12 no completion flagged");

    // R11 enable gating
    busWrite(4'd1, 32'hFFFF_1000);
    busWrite(4'd3, 32'd0);
    busWrite(4'd0, 32'h0008_0012);
    waitCycles(5);
    checkVal("R11 irq masked", {31'd0, irq}, 32'd0);
    busWrite(4'd3, 32'd1);
    checkVal("R11 irq enabled", {31'd0, irq}, 32'd1);

    finishRun();
  end

endmodule